// File: doc/BRIEF.md
# Prioritized Interrupt Request Core

This block is the request and in-service datapath of an eight-input interrupt controller. It registers eight level request lines and applies a mask supplied by a neighbouring configuration block. It then picks the lowest-numbered unmasked request that outranks everything already in service, and presents that request to the CPU as a pending flag and an 8-bit vector. The vector's upper five bits come from a programmable base. Its lower three bits are the winning line number.

The CPU takes an interrupt by pulsing an acknowledge strobe. That moves the winning line from the request register into the in-service register. The CPU finishes an interrupt with a decoded end-of-interrupt command. The command either names a level or clears the highest-priority in-service bit. A secondary controller's pending output can be fed into the cascade input, where it acts as request line 2. Both registers are exported for readback.

Top module: `intPrioCore`

## Requirements
- R1: Each request register bit follows its (cascade-merged) request line one clock after the line changes, unless that same edge acknowledges it.
- R2: `intPending` is 1 only when some request bit is set whose `maskBits` bit is 0 and which outranks every in-service bit. A masked line never raises it.
- R3: Line 0 has the highest priority and line 7 the lowest. While pending, `vecOut` = {`vecBase`, winning line number}. While not pending, `vecOut` is 0.
- R4: An acknowledge while pending clears the winner's request bit and sets its in-service bit on the same clock edge.
- R5: `eoiCmd` bits are [2]=end, [1]=rotate, [0]=select. A command 3'b101 with `eoiValid` clears the in-service bit numbered by `eoiLevel`.
- R6: A command 3'b100 with `eoiValid` clears only the lowest-numbered set in-service bit.
- R7: Any other `eoiCmd` value with `eoiValid` leaves the in-service register unchanged, and `cmdError` is 1 for exactly the following cycle.
- R8: `cascadeIn` acts as an extra source for request line 2, ORed with `reqLines[2]`.
- R9: A lower-numbered request is presented while a higher-numbered line is in service. A request of equal or lower priority than the lowest-numbered in-service line waits.
- R10: An acknowledge while nothing is pending changes neither register.
- R11: If a request line drops before acknowledge, pending deasserts one clock later and the in-service register is unchanged.
- R12: After reset, both registers are 0, `intPending` is 0 and `cmdError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqLines | input | 8 | Level request lines, bit n = line n |
| cascadeIn | input | 1 | Secondary controller's pending output, merged into line 2 |
| maskBits | input | 8 | 1 = line masked |
| vecBase | input | 5 | Upper bits of the vector |
| ackStrobe | input | 1 | CPU acknowledge, one cycle |
| eoiValid | input | 1 | End-of-interrupt command strobe |
| eoiCmd | input | 3 | {end, rotate, select} command bits |
| eoiLevel | input | 3 | Level for the specific end of interrupt |
| intPending | output | 1 | Interrupt request to the CPU |
| vecOut | output | 8 | Vector of the presented request |
| reqReg | output | 8 | Request register readback |
| svcReg | output | 8 | In-service register readback |
| cmdError | output | 1 | Unsupported command seen last cycle |

## Verification
On every cycle, the assertions check the acknowledge transfer and the fact that an idle acknowledge is harmless. They also check that an unsupported command leaves the in-service register intact, that a non-specific clear removes exactly one bit, and that pending never rises on masked requests alone. Only the bench's scenarios can show the exact priority order and vector values under different line and mask patterns. The same holds for nesting over an in-service line, the cascade merge on line 2, and the withdrawn-request case.

// File: rtl/intPrioPkg.sv
package intPrioPkg;
  localparam int NUM_LINES = 8;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - IDX_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             take;     // acknowledge accepted
    logic             clrSpec;  // clear in-service bit at level
    logic             clrLow;   // clear lowest in-service bit
    logic [IDX_W-1:0] level;
  } strobe_t;
endpackage

// File: rtl/intPrioCtrl.sv
module intPrioCtrl
  import intPrioPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ackStrobe,
  input  logic             eoiValid,
  input  logic [2:0]       eoiCmd,
  input  logic [IDX_W-1:0] eoiLevel,
  input  logic             pendNow,
  output strobe_t          strb,
  output logic             cmdError
);
  logic isEnd, isRot, isSel, badCmd;

  always_comb begin
    isEnd        = eoiCmd[2];
    isRot        = eoiCmd[1];
    isSel        = eoiCmd[0];
    badCmd       = eoiValid && !(isEnd && !isRot);
    strb.take    = ackStrobe && pendNow;
    strb.clrSpec = eoiValid && isEnd && !isRot && isSel;
    strb.clrLow  = eoiValid && isEnd && !isRot && !isSel;
    strb.level   = eoiLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdError <= 1'b0;
    else       cmdError <= badCmd;
  end

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!eoiValid) |=> !cmdError); // R7
endmodule

// File: rtl/intPrioPath.sv
module intPrioPath
  import intPrioPkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 cascadeIn,
  input  logic [NUM_LINES-1:0] maskBits,
  input  logic [BASE_W-1:0]    vecBase,
  input  strobe_t              strb,
  output logic                 pendNow,
  output logic [VEC_W-1:0]     vecOut,
  output logic [NUM_LINES-1:0] reqReg,
  output logic [NUM_LINES-1:0] svcReg
);
  logic [NUM_LINES-1:0] lineEff, cand, ackMask, clrMask;
  logic [IDX_W-1:0]     winIdx, svcIdx;
  logic                 winHit, svcHit;

  assign lineEff = reqLines | (NUM_LINES'(cascadeIn) << CASCADE_LINE);

  always_comb begin
    cand   = reqReg & ~maskBits;
    winIdx = '0;
    winHit = 1'b0;
    svcIdx = '0;
    svcHit = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && !winHit) begin
        winIdx = IDX_W'(i);
        winHit = 1'b1;
      end
      if (svcReg[i] && !svcHit) begin
        svcIdx = IDX_W'(i);
        svcHit = 1'b1;
      end
    end
    pendNow = winHit && (!svcHit || (winIdx < svcIdx));
    vecOut  = pendNow ? {vecBase, winIdx} : '0;
  end

  always_comb begin
    ackMask = strb.take ? (NUM_LINES'(1) << winIdx) : '0;
    if (strb.clrSpec)     clrMask = NUM_LINES'(1) << strb.level;
    else if (strb.clrLow) clrMask = svcReg & (~svcReg + NUM_LINES'(1));
    else                  clrMask = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg <= '0;
      svcReg <= '0;
    end else begin
      reqReg <= lineEff & ~ackMask;
      svcReg <= (svcReg & ~clrMask) | ackMask;
    end
  end

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !strb.clrSpec && !strb.clrLow)
      |=> (svcReg[$past(winIdx)] && !reqReg[$past(winIdx)])); // R4
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.take && !strb.clrSpec && !strb.clrLow) |=> $stable(svcReg)); // R10
  AST_LOW_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLow && !strb.take && (svcReg != '0))
      |=> ($countones(svcReg) + 1 == $countones($past(svcReg)))); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((reqReg & ~maskBits) == '0) |-> !pendNow); // R2
endmodule

// File: rtl/intPrioCore.sv
module intPrioCore
  import intPrioPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 cascadeIn,
  input  logic [NUM_LINES-1:0] maskBits,
  input  logic [BASE_W-1:0]    vecBase,
  input  logic                 ackStrobe,
  input  logic                 eoiValid,
  input  logic [2:0]           eoiCmd,
  input  logic [IDX_W-1:0]     eoiLevel,
  output logic                 intPending,
  output logic [VEC_W-1:0]     vecOut,
  output logic [NUM_LINES-1:0] reqReg,
  output logic [NUM_LINES-1:0] svcReg,
  output logic                 cmdError
);
  strobe_t strb;
  logic    pendNow;

  intPrioCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .eoiValid(eoiValid),
    .eoiCmd(eoiCmd), .eoiLevel(eoiLevel), .pendNow(pendNow),
    .strb(strb), .cmdError(cmdError)
  );

  intPrioPath #(.CASCADE_LINE(2)) i_path (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .cascadeIn(cascadeIn),
    .maskBits(maskBits), .vecBase(vecBase), .strb(strb), .pendNow(pendNow),
    .vecOut(vecOut), .reqReg(reqReg), .svcReg(svcReg)
  );

  assign intPending = pendNow;
endmodule

// File: tb/test_intPrioCore.sv
`timescale 1ns/1ps
module test_intPrioCore;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqLines = '0;
  logic       cascadeIn = 1'b0;
  logic [7:0] maskBits = '0;
  logic [4:0] vecBase = 5'b01000;
  logic       ackStrobe = 1'b0;
  logic       eoiValid = 1'b0;
  logic [2:0] eoiCmd = '0;
  logic [2:0] eoiLevel = '0;
  logic       intPending, cmdError;
  logic [7:0] vecOut, reqReg, svcReg;
  int         nRun = 0;
  int         nFail = 0;

  intPrioCore i_intPrioCore (.*);

  always #2.5 clk = ~clk;

  // table entry: lines[24:17] mask[16:9] pending[8] vector[7:0]
  localparam logic [24:0] TBL [0:6] = '{
    {8'h00, 8'h00, 1'b0, 8'h00},
    {8'h80, 8'h00, 1'b1, 8'h47},
    {8'h88, 8'h00, 1'b1, 8'h43},
    {8'h88, 8'h08, 1'b1, 8'h47},
    {8'hFF, 8'hFF, 1'b0, 8'h00},
    {8'h06, 8'h02, 1'b1, 8'h42},
    {8'h01, 8'h00, 1'b1, 8'h40}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eoi(logic [2:0] cmd, logic [2:0] lvl);
    eoiValid = 1'b1; eoiCmd = cmd; eoiLevel = lvl;
    tick();
    eoiValid = 1'b0;
  endtask

  task automatic ack();
    ackStrobe = 1'b1;
    tick();
    ackStrobe = 1'b0;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R12 pending", {7'd0, intPending}, 8'h00);
    chk("R12 req", reqReg, 8'h00);
    chk("R12 svc", svcReg, 8'h00);
    chk("R12 err", {7'd0, cmdError}, 8'h00);
    rstN = 1'b1;
    tick();

    for (int k = 0; k < 7; k++) begin
      reqLines = TBL[k][24:17];
      maskBits = TBL[k][16:9];
      tick();
      chk("R1 req follows lines", reqReg, TBL[k][24:17]);
      chk("R2 pending", {7'd0, intPending}, {7'd0, TBL[k][8]});
      chk("R3 vector", vecOut, TBL[k][7:0]);
    end
    reqLines = '0; maskBits = '0;
    tick();

    // acknowledge and nesting
    reqLines = 8'h20;
    tick();
    chk("R3 vector line5", vecOut, 8'h45);
    ack();
    chk("R4 req cleared", reqReg, 8'h00);
    chk("R4 svc set", svcReg, 8'h20);
    tick();
    chk("R9 equal waits", {7'd0, intPending}, 8'h00);
    reqLines = 8'h22;
    tick();
    chk("R9 nest pending", {7'd0, intPending}, 8'h01);
    chk("R9 nest vector", vecOut, 8'h41);
    ack();
    chk("R4 nested svc", svcReg, 8'h22);
    reqLines = 8'h20;
    eoi(3'b100, 3'd0);
    chk("R6 nonspecific", svcReg, 8'h20);
    eoi(3'b101, 3'd5);
    chk("R5 specific", svcReg, 8'h00);
    chk("R5 pending again", {7'd0, intPending}, 8'h01);
    reqLines = 8'h00;
    tick();
    chk("R11 dropped pending", {7'd0, intPending}, 8'h00);
    chk("R11 svc untouched", svcReg, 8'h00);

    // unsupported command
    reqLines = 8'h10;
    tick();
    ack();
    reqLines = 8'h00;
    chk("R4 line4 svc", svcReg, 8'h10);
    eoi(3'b110, 3'd4);
    chk("R7 error flag", {7'd0, cmdError}, 8'h01);
    chk("R7 svc kept", svcReg, 8'h10);
    eoi(3'b001, 3'd4);
    chk("R7 svc kept 2", svcReg, 8'h10);
    tick();
    chk("R7 error one cycle", {7'd0, cmdError}, 8'h00);
    eoi(3'b101, 3'd4);
    chk("R5 clear line4", svcReg, 8'h00);

    // idle acknowledge
    ack();
    chk("R10 idle ack", svcReg, 8'h00);
    reqLines = 8'h01; maskBits = 8'h01;
    tick();
    ack();
    chk("R10 masked ack svc", svcReg, 8'h00);
    chk("R10 masked ack req", reqReg, 8'h01);
    reqLines = 8'h00; maskBits = 8'h00;

    // cascade
    cascadeIn = 1'b1;
    tick();
    chk("R8 cascade req", reqReg, 8'h04);
    chk("R8 cascade vector", vecOut, 8'h42);
    cascadeIn = 1'b0;
    tick();

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule